// File: doc/BRIEF.md
# Stepped Frequency Sweep Sequencer

This block drives the frequency word of a DDS phase accumulator through a preprogrammed stepped profile. A host presents four values in parallel: the first frequency word, the amount added per step, how many increments the sweep contains, and how long each frequency is held. A rising edge on the control pin starts the sweep. From then on the block produces the current frequency word together with a one-cycle strobe on every advance. It also produces a completion pulse each time a saw sweep reaches its top.

The block supports three profiles. A saw profile climbs and then snaps back to the first word. A triangle profile climbs and then descends, and it turns around at both ends without repeating an endpoint. A hold profile stays on the first word. Each advance comes either from an internal dwell counter clocked by the master clock, or from each rising edge of the synchronised control pin. Configuration is captured when the sweep starts, and the sweep then runs until reset.

Top module: `sweep_prof_ctrl`

## Requirements
- R1: While rst_ni is low and after its release until a start, freq_o, step_o, done_o and busy_o are all 0.
- R2: When ctrl_i rises while idle, the pin passes through a two-flop synchroniser. At the third rising clock edge after ctrl_i goes high, busy_o becomes 1 and stays 1, freq_o takes start_freq_i, and step_o pulses.
- R3: With ext_step_i = 0 at start, every frequency is held for dwell_i clock cycles, and a dwell_i of 0 counts as 1.
- R4: With mode_i = 0 (saw), the increment index runs 0,1,..,N, then returns to 0 and repeats, where N = num_incr_i.
- R5: With mode_i = 1 (triangle), the index runs 0..N..0 repeatedly, with each reversal at N and at 0 taking no repeated step.
- R6: With mode_i = 2 or 3 (hold), or with N = 0, freq_o stays at the start word and step_o never pulses after the start.
- R7: With ext_step_i = 1 at start, each later synchronised rising edge of ctrl_i advances the profile at the third clock edge after the pin rises. The dwell counter has no effect in this case.
- R8: step_o is high for exactly the cycle that follows each frequency advance, including a saw wrap. freq_o does not change in any other cycle.
- R9: done_o pulses together with step_o when a saw sweep arrives at index N, and never in triangle or hold.
- R10: After the start, changes on start_freq_i, step_i, num_incr_i, dwell_i, mode_i and ext_step_i have no effect. With internal timing, edges on ctrl_i have no effect either.
- R11: freq_o equals start_freq_i plus index times step_i, modulo 2^24.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_freq_i | input | 24 | First frequency word of the profile |
| step_i | input | 24 | Amount added per increment |
| num_incr_i | input | 12 | Number of increments N |
| dwell_i | input | 16 | Clock cycles spent at each frequency |
| mode_i | input | 2 | 0 saw, 1 triangle, 2/3 hold |
| ext_step_i | input | 1 | 1: advance on control pin edges |
| ctrl_i | input | 1 | Asynchronous control pin, start and step |
| freq_o | output | 24 | Current frequency word |
| step_o | output | 1 | One-cycle strobe on each advance |
| done_o | output | 1 | Pulse when a saw sweep reaches index N |
| busy_o | output | 1 | Sweep running |

## Verification
The arrival at the top of a saw sweep makes the step strobe and the completion pulse fire in the same cycle. The very next advance is the wrap, which has a strobe and no completion pulse. A dwell of one provokes this densely, because every cycle is then an advance. The bench predicts both flags for each cycle from the index arithmetic and compares them together with the frequency word. A second collision is an edge on the control pin during an internally timed sweep while a dwell expiry lands. The bench toggles the pin every cycle and still expects the undisturbed sequence.

// File: rtl/sweep_prof_pkg.sv
package sweep_prof_pkg;
  typedef enum logic [1:0] {
    SWP_SAW  = 2'd0,
    SWP_TRI  = 2'd1,
    SWP_HOLD = 2'd2
  } sweep_mode_e;
endpackage

// File: rtl/sweep_prof_sync.sv
module sweep_prof_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic rise_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], d_i};
  end

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/sweep_prof_dwell.sv
module sweep_prof_dwell #(
  parameter int DWELL_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               en_i,
  input  logic [DWELL_W-1:0] limit_i,
  output logic               tick_o
);
  logic [DWELL_W-1:0] cnt_q;
  logic [DWELL_W-1:0] lim;

  // zero dwell behaves as one cycle
  assign lim    = (limit_i == '0) ? DWELL_W'(1) : limit_i;
  assign tick_o = en_i && (cnt_q == lim - DWELL_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (clr_i || tick_o) cnt_q <= '0;
    else if (en_i)            cnt_q <= cnt_q + DWELL_W'(1);
  end
endmodule

// File: rtl/sweep_prof_seq.sv
module sweep_prof_seq
  import sweep_prof_pkg::*;
#(
  parameter int FREQ_W = 24,
  parameter int INCR_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              adv_i,
  input  sweep_mode_e       mode_i,
  input  logic [FREQ_W-1:0] start_i,
  input  logic [FREQ_W-1:0] step_i,
  input  logic [INCR_W-1:0] last_i,
  output logic [FREQ_W-1:0] freq_o,
  output logic              step_o,
  output logic              done_o
);
  logic [INCR_W-1:0] idx_q;
  logic              up_q;
  logic              hold;

  assign hold = (mode_i == SWP_HOLD) || (last_i == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q  <= '0;
      up_q   <= 1'b1;
      freq_o <= '0;
      step_o <= 1'b0;
      done_o <= 1'b0;
    end else if (load_i) begin
      idx_q  <= '0;
      up_q   <= 1'b1;
      freq_o <= start_i;
      step_o <= 1'b1;
      done_o <= 1'b0;
    end else if (adv_i && !hold) begin
      step_o <= 1'b1;
      done_o <= 1'b0;
      if (mode_i == SWP_SAW) begin
        if (idx_q == last_i) begin
          idx_q  <= '0;
          freq_o <= start_i;
        end else begin
          idx_q  <= idx_q + INCR_W'(1);
          freq_o <= freq_o + step_i;
          done_o <= (INCR_W'(idx_q + INCR_W'(1)) == last_i);
        end
      end else if (up_q) begin
        // turn at the top without repeating it
        if (idx_q == last_i) begin
          up_q   <= 1'b0;
          idx_q  <= idx_q - INCR_W'(1);
          freq_o <= freq_o - step_i;
        end else begin
          idx_q  <= idx_q + INCR_W'(1);
          freq_o <= freq_o + step_i;
        end
      end else begin
        if (idx_q == '0) begin
          up_q   <= 1'b1;
          idx_q  <= INCR_W'(1);
          freq_o <= freq_o + step_i;
        end else begin
          idx_q  <= idx_q - INCR_W'(1);
          freq_o <= freq_o - step_i;
        end
      end
    end else begin
      step_o <= 1'b0;
      done_o <= 1'b0;
    end
  end
endmodule

// File: rtl/sweep_prof_ctrl.sv
module sweep_prof_ctrl
  import sweep_prof_pkg::*;
#(
  parameter int FREQ_W      = 24,
  parameter int INCR_W      = 12,
  parameter int DWELL_W     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [FREQ_W-1:0] start_freq_i,
  input  logic [FREQ_W-1:0] step_i,
  input  logic [INCR_W-1:0] num_incr_i,
  input  logic [DWELL_W-1:0] dwell_i,
  input  logic [1:0]        mode_i,
  input  logic              ext_step_i,
  input  logic              ctrl_i,
  output logic [FREQ_W-1:0] freq_o,
  output logic              step_o,
  output logic              done_o,
  output logic              busy_o
);
  logic               rise;
  logic               tick;
  logic               start_evt;
  logic               adv;
  logic               cfg_hold;
  sweep_mode_e        mode_q;
  logic               ext_q;
  logic [FREQ_W-1:0]  start_q;
  logic [FREQ_W-1:0]  step_q;
  logic [INCR_W-1:0]  last_q;
  logic [DWELL_W-1:0] dwell_q;
  sweep_mode_e        mode_dec;

  always_comb begin
    case (mode_i)
      2'd0:    mode_dec = SWP_SAW;
      2'd1:    mode_dec = SWP_TRI;
      default: mode_dec = SWP_HOLD;
    endcase
  end

  sweep_prof_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (ctrl_i),
    .rise_o(rise)
  );

  assign start_evt = rise && !busy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o  <= 1'b0;
      mode_q  <= SWP_HOLD;
      ext_q   <= 1'b0;
      start_q <= '0;
      step_q  <= '0;
      last_q  <= '0;
      dwell_q <= '0;
    end else if (start_evt) begin
      busy_o  <= 1'b1;
      mode_q  <= mode_dec;
      ext_q   <= ext_step_i;
      start_q <= start_freq_i;
      step_q  <= step_i;
      last_q  <= num_incr_i;
      dwell_q <= dwell_i;
    end
  end

  assign cfg_hold = (mode_q == SWP_HOLD) || (last_q == '0);

  sweep_prof_dwell #(.DWELL_W(DWELL_W)) u_dwell (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (start_evt),
    .en_i   (busy_o && !ext_q),
    .limit_i(dwell_q),
    .tick_o (tick)
  );

  assign adv = busy_o && (ext_q ? rise : tick);

  sweep_prof_seq #(.FREQ_W(FREQ_W), .INCR_W(INCR_W)) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (start_evt),
    .adv_i  (adv),
    .mode_i (start_evt ? mode_dec : mode_q),
    .start_i(start_evt ? start_freq_i : start_q),
    .step_i (step_q),
    .last_i (last_q),
    .freq_o (freq_o),
    .step_o (step_o),
    .done_o (done_o)
  );
endmodule

// File: rtl/sweep_prof_chk.sv
module sweep_prof_chk #(
  parameter int FREQ_W = 24
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [FREQ_W-1:0] freq_i,
  input logic              step_i,
  input logic              done_i,
  input logic              busy_i,
  input logic              hold_i
);
  // R2
  start_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> step_i);
  // R2
  busy_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> busy_i);
  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> (!step_i && !done_i && freq_i == '0));
  // R8
  freq_steady_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !step_i) |-> $stable(freq_i));
  // R9
  done_with_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> step_i);
  // R9
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !done_i);
  // R6
  hold_no_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_i && busy_i && $past(busy_i)) |-> (!step_i && $stable(freq_i)));
endmodule

bind sweep_prof_ctrl sweep_prof_chk #(.FREQ_W(FREQ_W)) u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .freq_i(freq_o),
  .step_i(step_o),
  .done_i(done_o),
  .busy_i(busy_o),
  .hold_i(cfg_hold)
);

// File: tb/sweep_prof_ctrl_tb_top.sv
module sweep_prof_ctrl_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [23:0] start_freq_i = '0;
  logic [23:0] step_i = '0;
  logic [11:0] num_incr_i = '0;
  logic [15:0] dwell_i = '0;
  logic [1:0]  mode_i = '0;
  logic        ext_step_i = 1'b0;
  logic        ctrl_i = 1'b0;
  logic [23:0] freq_o;
  logic        step_o, done_o, busy_o;

  int checks = 0;
  int errors = 0;

  always #10 clk_i = ~clk_i;

  sweep_prof_ctrl dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_freq_i(start_freq_i), .step_i(step_i),
    .num_incr_i(num_incr_i), .dwell_i(dwell_i), .mode_i(mode_i),
    .ext_step_i(ext_step_i), .ctrl_i(ctrl_i), .freq_o(freq_o), .step_o(step_o),
    .done_o(done_o), .busy_o(busy_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s t=%0t actual=%h expected=%h", req, $time, act, exp);
    end
  endtask

  function automatic int exp_idx(int mode, int n, int s);
    int p;
    if (mode >= 2 || n == 0) return 0;
    if (mode == 0) return s % (n + 1);
    p = s % (2 * n);
    return (p <= n) ? p : 2 * n - p;
  endfunction

  function automatic logic [23:0] exp_freq(logic [23:0] f0, logic [23:0] st, int idx);
    logic [23:0] i24;
    i24 = 24'(idx);
    return f0 + i24 * st;
  endfunction

  // R1 reset state, then R2 start with synchroniser latency
  task automatic start_run(int mode, int n, int d, logic [23:0] f0, logic [23:0] st, bit ext);
    @(negedge clk_i);
    rst_ni = 1'b0; ctrl_i = 1'b0;
    start_freq_i = f0; step_i = st; num_incr_i = 12'(n); dwell_i = 16'(d);
    mode_i = 2'(mode); ext_step_i = ext;
    @(posedge clk_i); #1;
    chk("R1 reset busy", {31'd0, busy_o}, 0);
    chk("R1 reset outs", {6'd0, freq_o, step_o, done_o}, 0);
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i); ctrl_i = 1'b1;
    @(posedge clk_i); @(posedge clk_i); #1;
    chk("R2 no early start", {31'd0, busy_o}, 0);
    chk("R1 idle freq", {8'd0, freq_o}, 0);
    @(posedge clk_i); #1;
  endtask

  task automatic run_auto(int mode, int n, int d, logic [23:0] f0, logic [23:0] st,
                          int cycles, bit scramble);
    int dm, s, idx;
    bit bnd, hold, e_step, e_done;
    dm = (d == 0) ? 1 : d;
    hold = (mode >= 2) || (n == 0);
    start_run(mode, n, d, f0, st, 1'b0);
    for (int t = 0; t < cycles; t++) begin
      if (t > 0) begin
        if (scramble) begin
          @(negedge clk_i);
          ctrl_i = ~ctrl_i;
          start_freq_i = start_freq_i ^ 24'h5a5a5a;
          step_i = step_i + 24'd3; num_incr_i = num_incr_i + 12'd1;
          dwell_i = dwell_i + 16'd1; mode_i = mode_i + 2'd1; ext_step_i = ~ext_step_i;
        end
        @(posedge clk_i); #1;
      end
      s = t / dm;
      bnd = (t % dm) == 0;
      idx = exp_idx(mode, n, s);
      e_step = (t == 0) || (!hold && bnd);
      e_done = (mode == 0) && !hold && bnd && (t > 0) && (idx == n);
      chk("R2 busy", {31'd0, busy_o}, 1);
      if (mode == 0) chk(scramble ? "R10 R4 saw freq" : "R4 R11 saw freq", {8'd0, freq_o}, {8'd0, exp_freq(f0, st, idx)});
      else if (mode == 1) chk("R5 R11 tri freq", {8'd0, freq_o}, {8'd0, exp_freq(f0, st, idx)});
      else chk("R6 hold freq", {8'd0, freq_o}, {8'd0, f0});
      chk(hold ? "R6 no step" : "R3 R8 step", {31'd0, step_o}, {31'd0, e_step});
      chk("R9 done", {31'd0, done_o}, {31'd0, e_done});
    end
  endtask

  // R7 external stepping, triangle profile, dwell of 1 must not advance
  task automatic run_ext();
    logic [23:0] f0, st;
    int n;
    f0 = 24'h001000; st = 24'h000100; n = 3;
    start_run(1, n, 1, f0, st, 1'b1);
    chk("R7 start step", {31'd0, step_o}, 1);
    for (int k = 0; k < 10; k++) begin
      @(posedge clk_i); #1;
      chk("R7 dwell ignored", {8'd0, freq_o}, {8'd0, f0});
      chk("R7 no step", {31'd0, step_o}, 0);
    end
    for (int s = 1; s <= 8; s++) begin
      @(negedge clk_i); ctrl_i = 1'b0;
      for (int k = 0; k < 3; k++) begin
        @(posedge clk_i); #1;
        chk("R7 fall ignored", {31'd0, step_o}, 0);
      end
      @(negedge clk_i); ctrl_i = 1'b1;
      @(posedge clk_i); @(posedge clk_i); #1;
      chk("R7 sync delay", {31'd0, step_o}, 0);
      @(posedge clk_i); #1;
      chk("R7 edge step", {31'd0, step_o}, 1);
      chk("R7 R5 edge freq", {8'd0, freq_o}, {8'd0, exp_freq(f0, st, exp_idx(1, n, s))});
      chk("R9 no done tri", {31'd0, done_o}, 0);
      @(posedge clk_i); #1;
      chk("R8 strobe one cycle", {31'd0, step_o}, 0);
    end
  endtask

  initial begin
    run_auto(0, 3, 1, 24'h000100, 24'h000010, 20, 1'b0);
    run_auto(0, 4, 3, 24'hFFFFF0, 24'h000007, 40, 1'b0);
    run_auto(1, 3, 2, 24'h123456, 24'h000111, 40, 1'b0);
    run_auto(1, 1, 0, 24'h000500, 24'h000050, 12, 1'b0);
    run_auto(2, 3, 1, 24'h0ABCDE, 24'h000001, 12, 1'b0);
    run_auto(3, 3, 1, 24'h00000F, 24'h000001, 8, 1'b0);
    run_auto(0, 0, 1, 24'h000777, 24'h000004, 8, 1'b0);
    run_auto(0, 2, 3, 24'h000200, 24'h000020, 30, 1'b1);
    run_ext();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    checks++; errors++;
    $display("FAIL R2 watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule